// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a free-running up-counter whose period is set by a compare register. A byte-addressed register port writes a two-byte mode word, two byte-wide compare-mode registers and two compare registers, and reads them back together with the live count. Setting the run bit in the high mode byte restarts the counter from zero. It also copies compare register A into a private period register. From then on the counter advances by one every clock. When it equals the period, it emits a one-cycle period pulse and wraps to zero.

Two match outputs pulse while the running count equals the present contents of compare register A or compare register B. Any illegal write is refused and leaves state unchanged. Illegal writes are: reserved mode bits set, run and load requested together, a halfword to a byte-only register, any write to the counter, or an unmapped address. A refused write sets a sticky error flag that only reset clears. The counter is 16 bits wide. Register reads are combinational from the address.

Top module: `ucmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter reads zero, and the period, match and error outputs are low.
- R2: Whenever the run bit is clear the counter reads zero. An accepted write that clears run (high mode byte bit 7) zeroes the counter at that clock edge and holds it there.
- R3: An accepted write to the high mode byte with bit 7 set makes the counter read zero in the next cycle. The counter then increases by one per clock.
- R4: The period is captured from compare register A on each accepted run write. When the count equals the period, the period output is high for that cycle and the count reads zero in the next cycle, giving P+1 cycles per period. Later writes to compare A do not alter the captured period.
- R5: The compare-A match output is high exactly in cycles where the timer runs and the count equals the current compare register A.
- R6: The compare-B match output is high exactly in cycles where the timer runs and the count equals the current compare register B.
- R7: The low mode byte sits at 0x84 and the high byte at 0x85. A halfword write or read at 0x84 carries the low byte in data bits 7:0 and the high byte in bits 15:8. A byte read at 0x85 returns the high byte.
- R8: Reserved mode bits must be zero: low byte bits 5, 3 and 2 (mask 0x2C), and high byte bits 2:0 (mask 0x07). A write that sets one is refused and sets the error flag. A halfword write at 0x84 is refused whole if either byte is bad.
- R9: A high mode byte with bit 7 (run) and bit 6 (load) both set is refused and sets the error flag. The load bit alone is stored and has no effect on counting.
- R10: Compare A (0xC4) and compare B (0xD4) take a halfword write as the full value. A byte write replaces bits 7:0 and keeps bits 15:8.
- R11: The compare-mode bytes at 0xB4 and 0xB5 accept byte writes and read back. A halfword write to either is refused and sets the error flag.
- R12: The counter at 0xA4 is read-only. A write there is refused, sets the error flag and leaves the count sequence undisturbed. A write to any unmapped address also sets the flag.
- R13: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_half | input | 1 | 1 = halfword write, 0 = byte write |
| addr | input | 8 | Register byte address, used for reads and writes |
| wdata | input | 16 | Write data, byte writes use bits 7:0 |
| rdata | output | 16 | Read data for addr, zero-extended for byte registers |
| err_o | output | 1 | Sticky refused-write flag |
| period_o | output | 1 | Period pulse, count equals captured period |
| match_a_o | output | 1 | Count equals compare A while running |
| match_b_o | output | 1 | Count equals compare B while running |

## Verification
A wrong count or a stale period register shows up at the counter read port in the very next cycle. It also shows as a period pulse that lands on the wrong cycle of the wrap, within one period of the fault. A mode register that accepts a reserved or conflicting pattern is visible on the first readback after the write, and in the error flag one cycle after the strobe. Match pulses are compared cycle by cycle against the count modulo P+1, over a sweep of small periods and compare-B values, so any compare error appears inside the first period.

// File: rtl/ucmp_pkg.sv
package ucmp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 8'h85;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_CCM_A   = 8'hB4;
  localparam logic [ADDR_W-1:0] OFS_CCM_B   = 8'hB5;
  localparam logic [ADDR_W-1:0] OFS_CMP_A   = 8'hC4;
  localparam logic [ADDR_W-1:0] OFS_CMP_B   = 8'hD4;

  localparam logic [BYTE_W-1:0] LO_RSVD  = 8'h2C;
  localparam logic [BYTE_W-1:0] HI_RSVD  = 8'h07;
  localparam logic [BYTE_W-1:0] HI_RUN   = 8'h80;
  localparam logic [BYTE_W-1:0] HI_LOAD  = 8'h40;
  localparam int                RUN_BIT  = 7;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_MODE_LO, TGT_MODE_HI, TGT_COUNT,
    TGT_CCM_A, TGT_CCM_B, TGT_CMP_A, TGT_CMP_B
  } target_e;

  function automatic target_e decode_tgt(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MODE_LO: decode_tgt = TGT_MODE_LO;
      OFS_MODE_HI: decode_tgt = TGT_MODE_HI;
      OFS_COUNT:   decode_tgt = TGT_COUNT;
      OFS_CCM_A:   decode_tgt = TGT_CCM_A;
      OFS_CCM_B:   decode_tgt = TGT_CCM_B;
      OFS_CMP_A:   decode_tgt = TGT_CMP_A;
      OFS_CMP_B:   decode_tgt = TGT_CMP_B;
      default:     decode_tgt = TGT_NONE;
    endcase
  endfunction

  function automatic logic lo_legal(input logic [BYTE_W-1:0] v);
    lo_legal = ((v & LO_RSVD) == '0);
  endfunction

  function automatic logic hi_legal(input logic [BYTE_W-1:0] v);
    hi_legal = ((v & HI_RSVD) == '0) && ((v & (HI_RUN | HI_LOAD)) != (HI_RUN | HI_LOAD));
  endfunction
endpackage

// File: rtl/ucmp_regs.sv
module ucmp_regs
  import ucmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_half,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [W-1:0]        wdata,
  output logic [BYTE_W-1:0]   mode_lo,
  output logic [BYTE_W-1:0]   mode_hi,
  output logic [BYTE_W-1:0]   ccm_a,
  output logic [BYTE_W-1:0]   ccm_b,
  output logic [W-1:0]        cmp_a,
  output logic [W-1:0]        cmp_b,
  output logic                err,
  output logic                hi_wr,
  output logic [BYTE_W-1:0]   hi_val
);
  localparam int HALF_W = 2 * BYTE_W;

  target_e           tgt;
  logic [BYTE_W-1:0] lo_new, hi_new;
  logic              lo_we, hi_we, ccm_a_we, ccm_b_we, cmp_a_we, cmp_b_we;
  logic              accept;
  logic              err_d;
  logic [W-1:0]      cmp_a_d, cmp_b_d;

  always_comb begin
    tgt      = decode_tgt(addr);
    lo_new   = wdata[BYTE_W-1:0];
    hi_new   = (tgt == TGT_MODE_LO) ? wdata[HALF_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    accept   = 1'b0;
    lo_we    = 1'b0;
    hi_we    = 1'b0;
    ccm_a_we = 1'b0;
    ccm_b_we = 1'b0;
    cmp_a_we = 1'b0;
    cmp_b_we = 1'b0;
    case (tgt)
      TGT_MODE_LO: begin
        if (wr_half) begin
          accept = lo_legal(lo_new) && hi_legal(hi_new);
          lo_we  = accept;
          hi_we  = accept;
        end else begin
          accept = lo_legal(lo_new);
          lo_we  = accept;
        end
      end
      TGT_MODE_HI: begin
        accept = !wr_half && hi_legal(hi_new);
        hi_we  = accept;
      end
      TGT_CCM_A: begin
        accept   = !wr_half;
        ccm_a_we = accept;
      end
      TGT_CCM_B: begin
        accept   = !wr_half;
        ccm_b_we = accept;
      end
      TGT_CMP_A: begin
        accept   = 1'b1;
        cmp_a_we = 1'b1;
      end
      TGT_CMP_B: begin
        accept   = 1'b1;
        cmp_b_we = 1'b1;
      end
      default: accept = 1'b0;
    endcase
    cmp_a_d = wr_half ? wdata : {cmp_a[W-1:BYTE_W], wdata[BYTE_W-1:0]};
    cmp_b_d = wr_half ? wdata : {cmp_b[W-1:BYTE_W], wdata[BYTE_W-1:0]};
    err_d   = err || (wr_en && !accept);
  end

  assign hi_wr  = wr_en && hi_we;
  assign hi_val = hi_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo <= '0;
    end else if (wr_en && lo_we) begin
      mode_lo <= lo_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_hi <= '0;
    end else if (wr_en && hi_we) begin
      mode_hi <= hi_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccm_a <= '0;
    end else if (wr_en && ccm_a_we) begin
      ccm_a <= wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccm_b <= '0;
    end else if (wr_en && ccm_b_we) begin
      ccm_b <= wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
    end else if (wr_en && cmp_a_we) begin
      cmp_a <= cmp_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_b <= '0;
    end else if (wr_en && cmp_b_we) begin
      cmp_b <= cmp_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else begin
      err <= err_d;
    end
  end
endmodule

// File: rtl/ucmp_counter.sv
module ucmp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run_next,
  input  logic         run,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt,
  output logic         period_hit,
  output logic         match_a,
  output logic         match_b
);
  logic [W-1:0] per_q;
  logic [W-1:0] cnt_d, per_d;
  logic         cnt_en, per_en;

  always_comb begin
    period_hit = run && (cnt == per_q);
    match_a    = run && (cnt == cmp_a);
    match_b    = run && (cnt == cmp_b);
  end

  always_comb begin
    cnt_en = 1'b1;
    per_en = restart && run_next;
    per_d  = cmp_a;
    if (restart) begin
      cnt_d = '0;
    end else if (!run) begin
      cnt_d  = '0;
      cnt_en = (cnt != '0);
    end else if (period_hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
    end else if (per_en) begin
      per_q <= per_d;
    end
  end
endmodule

// File: rtl/ucmp_rdmux.sv
module ucmp_rdmux
  import ucmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] mode_lo,
  input  logic [BYTE_W-1:0] mode_hi,
  input  logic [BYTE_W-1:0] ccm_a,
  input  logic [BYTE_W-1:0] ccm_b,
  input  logic [W-1:0]      cmp_a,
  input  logic [W-1:0]      cmp_b,
  input  logic [W-1:0]      cnt,
  output logic [W-1:0]      rdata
);
  localparam int PAD_W = W - 2 * BYTE_W;

  always_comb begin
    case (decode_tgt(addr))
      TGT_MODE_LO: rdata = {{PAD_W{1'b0}}, mode_hi, mode_lo};
      TGT_MODE_HI: rdata = W'(mode_hi);
      TGT_COUNT:   rdata = cnt;
      TGT_CCM_A:   rdata = W'(ccm_a);
      TGT_CCM_B:   rdata = W'(ccm_b);
      TGT_CMP_A:   rdata = cmp_a;
      TGT_CMP_B:   rdata = cmp_b;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/ucmp_timer.sv
module ucmp_timer
  import ucmp_pkg::*;
#(
  parameter int W        = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              err_o,
  output logic              period_o,
  output logic              match_a_o,
  output logic              match_b_o
);
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_n_sync;
  logic [BYTE_W-1:0]   mode_lo, mode_hi, ccm_a, ccm_b, hi_val;
  logic [W-1:0]        cmp_a, cmp_b, cnt;
  logic                hi_wr, run, run_next, err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[SYNC_LEN-1];

  ucmp_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_half (wr_half),
    .addr    (addr),
    .wdata   (wdata),
    .mode_lo (mode_lo),
    .mode_hi (mode_hi),
    .ccm_a   (ccm_a),
    .ccm_b   (ccm_b),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .err     (err),
    .hi_wr   (hi_wr),
    .hi_val  (hi_val)
  );

  assign run      = mode_hi[RUN_BIT];
  assign run_next = hi_val[RUN_BIT];

  ucmp_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .restart    (hi_wr),
    .run_next   (run_next),
    .run        (run),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .cnt        (cnt),
    .period_hit (period_o),
    .match_a    (match_a_o),
    .match_b    (match_b_o)
  );

  ucmp_rdmux #(.W(W)) u_rd (
    .addr    (addr),
    .mode_lo (mode_lo),
    .mode_hi (mode_hi),
    .ccm_a   (ccm_a),
    .ccm_b   (ccm_b),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .cnt     (cnt),
    .rdata   (rdata)
  );

  assign err_o = err;
endmodule

// File: rtl/ucmp_timer_checker.sv
module ucmp_timer_checker
  import ucmp_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [W-1:0]      cnt,
  input logic              period_o,
  input logic              match_a_o,
  input logic              match_b_o,
  input logic              err_o,
  input logic              wr_en,
  input logic              wr_half,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        wtop,
  input logic              restart
);
  assert_stopped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt == '0);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !period_o && !restart |=> cnt == W'($past(cnt) + 1'b1));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_o |=> cnt == '0);

  assert_match_a_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_a_o |-> run);

  assert_match_b_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_b_o |-> run);

  assert_run_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_half && addr == OFS_MODE_HI && wtop == 2'b11 |=> err_o);

  assert_count_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == OFS_COUNT |=> err_o);

  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind ucmp_timer ucmp_timer_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .run       (run),
  .cnt       (cnt),
  .period_o  (period_o),
  .match_a_o (match_a_o),
  .match_b_o (match_b_o),
  .err_o     (err_o),
  .wr_en     (wr_en),
  .wr_half   (wr_half),
  .addr      (addr),
  .wtop      (wdata[7:6]),
  .restart   (hi_wr)
);

// File: tb/ucmp_timer_bench.sv
module ucmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_half;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        err_o, period_o, match_a_o, match_b_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ucmp_timer u_ucmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_half(wr_half),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err_o(err_o),
    .period_o(period_o), .match_a_o(match_a_o), .match_b_o(match_b_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; wr_half = 0; addr = 8'h00; wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic h);
    @(negedge clk);
    addr = a; wdata = d; wr_half = h; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  function automatic bit hi_ok(input logic [7:0] v);
    return ((v & 8'h07) == 0) && ((v & 8'hC0) != 8'hC0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, prev, c0;
    bit experr;
    do_reset();

    // R1: reset state
    foreach (addr_list[i]) begin
      rd(addr_list[i], v);
      chk("R1 reg zero", v, 0);
    end
    chk("R1 period", period_o, 0);
    chk("R1 match_a", match_a_o, 0);
    chk("R1 match_b", match_b_o, 0);
    chk("R1 err", err_o, 0);

    // R7: halfword mode layout
    wr(8'h84, 16'h4011, 1);
    rd(8'h84, v); chk("R7 half read", v, 16'h4011);
    rd(8'h85, v); chk("R7 high byte", v, 16'h0040);
    chk("R7 no err", err_o, 0);
    rd(8'hA4, v); chk("R9 load alone no count", v, 0);

    // R8: low byte reserved sweep
    do_reset();
    prev = 0; experr = 0;
    for (int i = 0; i < 256; i++) begin
      bit ok;
      ok = ((i & 8'h2C) == 0);
      wr(8'h84, 16'(i), 0);
      rd(8'h84, v);
      if (ok) prev = 16'(i);
      else experr = 1;
      chk("R8 low byte", {16'h0, v[7:0]}, {16'h0, prev[7:0]});
      chk("R13 err low", err_o, experr);
    end

    // R8/R9: high byte sweep
    do_reset();
    prev = 0; experr = 0;
    for (int i = 0; i < 256; i++) begin
      wr(8'h85, 16'(i), 0);
      rd(8'h85, v);
      if (hi_ok(8'(i))) prev = 16'(i);
      else experr = 1;
      if ((i & 8'hC0) == 8'hC0) chk("R9 run+load refused", v, prev);
      else chk("R8 high byte", v, prev);
      chk("R13 err high", err_o, experr);
    end
    wr(8'h85, 16'h0000, 0);

    // R8: halfword rejected whole if one byte bad
    do_reset();
    wr(8'h84, 16'h0124, 1);
    rd(8'h84, v); chk("R8 half refused", v, 0);
    chk("R8 err", err_o, 1);

    // R10
    do_reset();
    wr(8'hC4, 16'h1234, 1); rd(8'hC4, v); chk("R10 cmpA half", v, 16'h1234);
    wr(8'hC4, 16'hFFAB, 0); rd(8'hC4, v); chk("R10 cmpA byte", v, 16'h12AB);
    wr(8'hD4, 16'hBEEF, 1); rd(8'hD4, v); chk("R10 cmpB half", v, 16'hBEEF);
    wr(8'hD4, 16'h0011, 0); rd(8'hD4, v); chk("R10 cmpB byte", v, 16'hBE11);
    chk("R10 no err", err_o, 0);

    // R11
    wr(8'hB4, 16'h005A, 0); rd(8'hB4, v); chk("R11 ccmA", v, 16'h005A);
    wr(8'hB5, 16'h00A5, 0); rd(8'hB5, v); chk("R11 ccmB", v, 16'h00A5);
    chk("R11 no err", err_o, 0);
    wr(8'hB4, 16'h1111, 1); rd(8'hB4, v); chk("R11 half refused", v, 16'h005A);
    chk("R11 err", err_o, 1);
    repeat (5) @(negedge clk);
    chk("R13 err held", err_o, 1);

    // R12: counter read-only while running
    do_reset();
    wr(8'hC4, 16'd200, 1);
    wr(8'h85, 16'h0080, 0);
    repeat (3) @(negedge clk);
    rd(8'hA4, c0);
    wr(8'hA4, 16'h0055, 1);
    rd(8'hA4, v);
    chk("R12 count undisturbed", v, c0 + 16'd2);
    chk("R12 err", err_o, 1);
    // R2: stop clears
    wr(8'h85, 16'h0000, 0);
    rd(8'hA4, v); chk("R2 stopped zero", v, 0);
    repeat (4) @(negedge clk);
    rd(8'hA4, v); chk("R2 stays zero", v, 0);
    chk("R2 no period", period_o, 0);

    do_reset();
    wr(8'h00, 16'h0001, 0);
    chk("R12 unmapped err", err_o, 1);

    // R3-R6: period sweep
    do_reset();
    for (int p = 0; p <= 12; p++) begin
      int b;
      b = p / 2;
      wr(8'hC4, 16'(p), 1);
      wr(8'hD4, 16'(b), 1);
      wr(8'h85, 16'h0080, 0);
      addr = 8'hA4;
      for (int k = 0; k < 3 * (p + 1); k++) begin
        int e;
        if (k > 0) @(negedge clk);
        #1;
        e = k % (p + 1);
        chk("R3 count", rdata, 16'(e));
        chk("R4 period", period_o, (e == p));
        chk("R5 match A", match_a_o, (e == p));
        chk("R6 match B", match_b_o, (e == b));
      end
      wr(8'h85, 16'h0000, 0);
      rd(8'hA4, v); chk("R2 stop", v, 0);
      chk("R5 stopped", match_a_o, (p == 0) ? 0 : 0);
      chk("R6 stopped", match_b_o, 0);
    end

    // R4: captured period ignores later compare A writes
    wr(8'hC4, 16'd5, 1);
    wr(8'h85, 16'h0080, 0);
    wr(8'hC4, 16'd9, 1);
    addr = 8'hA4;
    for (int j = 0; j < 24; j++) begin
      int e;
      if (j > 0) @(negedge clk);
      #1;
      e = (j + 2) % 6;
      chk("R4 latched period", period_o, (e == 5));
      chk("R4 count", rdata, 16'(e));
      chk("R5 cmpA changed", match_a_o, 0);
    end
    chk("R1 err clear", err_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] addr_list [7] = '{8'h84, 8'h85, 8'hA4, 8'hB4, 8'hB5, 8'hC4, 8'hD4};
endmodule